// File: doc/BRIEF.md
# Masked Fallback Lookup Bitmap

This block holds a 4096-entry, one-bit-wide flag table that acts as a second-chance lookup behind a primary associative memory. On a compare request, the top twelve bits of the 32-bit comparand are taken as an index. These bits hold the virtual path identifier of an ATM cell header. The index is ANDed with a twelve-bit mask from the configuration word, and the flag at the masked index is read. The primary memory is not part of the block. Its outcome arrives on the `pri_match` and `pri_addr` inputs.

A registered state machine combines the two outcomes and presents one result in the cycle after the request:
- A primary match always wins over a table hit.
- A table hit is reported with the masked index on the address output and the page identifier on the page output.
- If neither source hits, the result is a miss.

A separate write port loads the table one bit at a time. No reset of any kind touches the table contents.

The state machine has four states:
- `ST_IDLE`: no result.
- `ST_PRI_HIT`: primary match.
- `ST_TBL_HIT`: table hit with no primary match.
- `ST_MISS`: neither source hit.

On every clock edge the next state is chosen from the current request, whatever the current state is:
- IDLE when `cmp_req` is low or `sw_rst` is high.
- PRI_HIT when `cmp_req` and `pri_match` are high.
- TBL_HIT when the table is enabled and the masked flag reads 0.
- MISS otherwise.

Top module: `fallback_lookup_map`

## Requirements
- R1: After `rst_n` is released, and with no compare request, `res_valid`=0, `match_any_n`=1, `match_pri_n`=1, `hit_addr`=0 and `hit_page`=0.
- R2: A write with `wr_en`=1 stores `wr_val` at `wr_idx` on the next clock edge. A compare in the same cycle sees the value held before that write.
- R3: A stored 0 is a hit and a stored 1 is a miss. Suppose a compare is made with the table enabled and `pri_match`=0. If the flag at the masked index is 0, the next cycle shows `res_valid`=1, `match_any_n`=0, `match_pri_n`=1, `hit_addr` equal to the masked index and `hit_page` equal to `page_id`.
- R4: The lookup index is `comparand[31:20] & cfg_word[23:12]`. Mask bits at 0 force the matching index bits to 0. All other `cfg_word` bits and `comparand[19:0]` have no effect.
- R5: The table takes part only when `cfg_word[24]`=1. With `cfg_word[24]`=0 and `pri_match`=0, a compare always yields a miss. `match_pri_n`=0 only ever occurs together with `match_any_n`=0.
- R6: A compare with `pri_match`=1 yields `match_any_n`=0, `match_pri_n`=0, `hit_addr`=`pri_addr` and `hit_page`=`page_id`, whatever the table holds.
- R7: A miss yields `res_valid`=1, `match_any_n`=1, `match_pri_n`=1, `hit_addr`=0 and `hit_page`=0.
- R8: A result is shown only in the cycle after the clock edge that sampled `cmp_req`=1. With no request, the outputs return to the R1 values.
- R9: Neither `rst_n` nor `sw_rst` alters the table contents. `sw_rst`=1 at an edge forces the idle outputs in the next cycle, even when `cmp_req`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the result logic |
| sw_rst | input | 1 | Synchronous reset of the result logic |
| cfg_word | input | 32 | Configuration: bit 24 enables the table, bits 23:12 hold the index mask |
| page_id | input | 4 | Page identifier reported with a hit |
| wr_en | input | 1 | Write one table bit |
| wr_idx | input | 12 | Table index to write |
| wr_val | input | 1 | Bit value to write (0 = hit) |
| cmp_req | input | 1 | Compare request |
| comparand | input | 32 | Comparand; bits 31:20 form the index |
| pri_match | input | 1 | Primary memory matched |
| pri_addr | input | 12 | Primary memory match address |
| res_valid | output | 1 | A result is shown this cycle |
| match_any_n | output | 1 | Active-low match from either source |
| match_pri_n | output | 1 | Active-low primary-only match |
| hit_addr | output | 12 | Match address or masked table index |
| hit_page | output | 4 | Page identifier of the hit |

## Verification
A table write and a compare can land in the same cycle on the same index. The bench provokes this by driving `wr_en` and `cmp_req` together with the written index equal to the masked comparand index, and with the written value the inverse of the stored one. The first result is judged against the bench's model before the update. A second compare is then judged against the updated model. A primary match and a table hit can also coincide. The bench sweeps `pri_match` against table contents that hold 0s and 1s under several masks, and expects the primary address every time.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

    // Configuration word layout
    localparam int CFG_EN_BIT   = 24;
    localparam int CFG_MASK_LSB = 12;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRI_HIT = 2'd1,
        ST_TBL_HIT = 2'd2,
        ST_MISS    = 2'd3
    } lkp_state_e;

endpackage

// File: rtl/lkp_index.sv
module lkp_index #(
    parameter int IDX_W = 12
) (
    input  logic [IDX_W-1:0] raw_idx,
    input  logic [IDX_W-1:0] idx_mask,
    output logic [IDX_W-1:0] masked_idx
);

    // Mask zeros clear index bits; each bit is a plain AND gate
    for (genvar b = 0; b < IDX_W; b++) begin : g_mask
        assign masked_idx[b] = raw_idx[b] & idx_mask[b];
    end

endmodule

// File: rtl/lkp_flag_store.sv
module lkp_flag_store #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    localparam int DEPTH = 1 << IDX_W;

    // Contents survive every reset, so no reset term here
    logic [DEPTH-1:0] flags;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            flags[wr_idx] <= wr_val;
        end
    end

    // Read returns the value before any write in this cycle
    assign rd_bit = flags[rd_idx];

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flags[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/lkp_result_fsm.sv
module lkp_result_fsm
    import lkp_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              cmp_req,
    input  logic              pri_match,
    input  logic [IDX_W-1:0]  pri_addr,
    input  logic              tbl_en,
    input  logic              tbl_bit,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [PAGE_W-1:0] page_id,
    output logic              res_valid,
    output logic              match_any_n,
    output logic              match_pri_n,
    output logic [IDX_W-1:0]  hit_addr,
    output logic [PAGE_W-1:0] hit_page
);

    lkp_state_e        state, nxt;
    logic [IDX_W-1:0]  addr_q, addr_d;
    logic [PAGE_W-1:0] page_q, page_d;

    // Next-state choice: the primary match outranks a table hit
    always_comb begin
        nxt = ST_IDLE;
        if (cmp_req && !sw_rst) begin
            if (pri_match) begin
                nxt = ST_PRI_HIT;
            end else if (tbl_en && !tbl_bit) begin
                nxt = ST_TBL_HIT;
            end else begin
                nxt = ST_MISS;
            end
        end
    end

    always_comb begin
        addr_d = '0;
        page_d = '0;
        unique case (nxt)
            ST_PRI_HIT: begin
                addr_d = pri_addr;
                page_d = page_id;
            end
            ST_TBL_HIT: begin
                addr_d = tbl_idx;
                page_d = page_id;
            end
            ST_IDLE, ST_MISS: begin
                addr_d = '0;
                page_d = '0;
            end
            default: begin
                addr_d = '0;
                page_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            page_q <= '0;
        end else begin
            state  <= nxt;
            addr_q <= addr_d;
            page_q <= page_d;
        end
    end

    // Outputs
    always_comb begin
        res_valid   = 1'b0;
        match_any_n = 1'b1;
        match_pri_n = 1'b1;
        unique case (state)
            ST_IDLE: begin
                res_valid = 1'b0;
            end
            ST_PRI_HIT: begin
                res_valid   = 1'b1;
                match_any_n = 1'b0;
                match_pri_n = 1'b0;
            end
            ST_TBL_HIT: begin
                res_valid   = 1'b1;
                match_any_n = 1'b0;
            end
            ST_MISS: begin
                res_valid = 1'b1;
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end

    assign hit_addr = addr_q;
    assign hit_page = page_q;

    // R6
    pri_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && pri_match && !sw_rst) |=>
            (!match_pri_n && !match_any_n && hit_addr == $past(pri_addr)));

    // R5
    pri_implies_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_pri_n |-> !match_any_n);

    // R8
    res_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(cmp_req) && !$past(sw_rst)));

    // R7
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_any_n |-> (hit_addr == '0 && hit_page == '0));

    // R9
    sw_rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !res_valid);

endmodule

// File: rtl/fallback_lookup_map.sv
module fallback_lookup_map
    import lkp_pkg::*;
#(
    parameter int CMP_W  = 32,
    parameter int CFG_W  = 32,
    parameter int IDX_W  = 12,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [PAGE_W-1:0] page_id,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_val,
    input  logic              cmp_req,
    input  logic [CMP_W-1:0]  comparand,
    input  logic              pri_match,
    input  logic [IDX_W-1:0]  pri_addr,
    output logic              res_valid,
    output logic              match_any_n,
    output logic              match_pri_n,
    output logic [IDX_W-1:0]  hit_addr,
    output logic [PAGE_W-1:0] hit_page
);

    localparam int IDX_LSB = CMP_W - IDX_W;

    logic [IDX_W-1:0] raw_idx;
    logic [IDX_W-1:0] idx_mask;
    logic [IDX_W-1:0] masked_idx;
    logic             tbl_en;
    logic             tbl_bit;
    logic             unused_bits;

    assign raw_idx  = comparand[CMP_W-1:IDX_LSB];
    assign idx_mask = cfg_word[CFG_MASK_LSB +: IDX_W];
    assign tbl_en   = cfg_word[CFG_EN_BIT];
    assign unused_bits = ^{comparand[IDX_LSB-1:0],
                           cfg_word[CFG_W-1:CFG_EN_BIT+1],
                           cfg_word[CFG_MASK_LSB-1:0]};

    lkp_index #(.IDX_W(IDX_W)) u_index (
        .raw_idx    (raw_idx),
        .idx_mask   (idx_mask),
        .masked_idx (masked_idx)
    );

    lkp_flag_store #(.IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .rd_idx (masked_idx),
        .rd_bit (tbl_bit)
    );

    lkp_result_fsm #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_rst      (sw_rst),
        .cmp_req     (cmp_req),
        .pri_match   (pri_match),
        .pri_addr    (pri_addr),
        .tbl_en      (tbl_en),
        .tbl_bit     (tbl_bit),
        .tbl_idx     (masked_idx),
        .page_id     (page_id),
        .res_valid   (res_valid),
        .match_any_n (match_any_n),
        .match_pri_n (match_pri_n),
        .hit_addr    (hit_addr),
        .hit_page    (hit_page)
    );

    // R4
    masked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && !sw_rst && !pri_match) |=>
            (match_any_n || (hit_addr & ~$past(idx_mask)) == '0));

    // R5
    disabled_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && !sw_rst && !pri_match && !tbl_en) |=> match_any_n);

endmodule

// File: tb/sim_fallback_lookup_map.sv
module sim_fallback_lookup_map;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [3:0]  page_id = 4'h9;
    logic        wr_en = 1'b0;
    logic [11:0] wr_idx = '0;
    logic        wr_val = 1'b0;
    logic        cmp_req = 1'b0;
    logic [31:0] comparand = '0;
    logic        pri_match = 1'b0;
    logic [11:0] pri_addr = '0;
    logic        res_valid, match_any_n, match_pri_n;
    logic [11:0] hit_addr;
    logic [3:0]  hit_page;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  model [4096];

    localparam logic [18:0] IDLE_OUT = {1'b0, 1'b1, 1'b1, 4'h0, 12'h000};

    always #10 clk = ~clk;

    fallback_lookup_map u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_word(cfg_word),
        .page_id(page_id), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .cmp_req(cmp_req), .comparand(comparand), .pri_match(pri_match),
        .pri_addr(pri_addr), .res_valid(res_valid), .match_any_n(match_any_n),
        .match_pri_n(match_pri_n), .hit_addr(hit_addr), .hit_page(hit_page)
    );

    function automatic logic [18:0] outs();
        return {res_valid, match_any_n, match_pri_n, hit_page, hit_addr};
    endfunction

    function automatic logic [18:0] expect_res(logic [11:0] idx, logic [11:0] msk,
                                               bit en, bit pri, logic [11:0] paddr);
        logic [11:0] m;
        m = idx & msk;
        if (pri) return {1'b1, 1'b0, 1'b0, page_id, paddr};
        if (en && model[m] == 1'b0) return {1'b1, 1'b0, 1'b1, page_id, m};
        return {1'b1, 1'b1, 1'b1, 4'h0, 12'h000};
    endfunction

    task automatic chk(string req, logic [18:0] act, logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp);
        end
    endtask

    // Bits outside the used fields carry junk to show they are ignored (R4)
    function automatic logic [31:0] mk_cfg(bit en, logic [11:0] msk);
        return {7'h55, en, msk, 12'hA5C};
    endfunction

    task automatic wr(logic [11:0] idx, bit v);
        wr_en = 1'b1; wr_idx = idx; wr_val = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[idx] = v;
    endtask

    task automatic cmp(string req, logic [11:0] idx, logic [11:0] msk, bit en,
                       bit pri, logic [11:0] paddr);
        logic [18:0] e;
        cfg_word  = mk_cfg(en, msk);
        comparand = {idx, 20'(idx * 977 + 5)};
        pri_match = pri; pri_addr = paddr; cmp_req = 1'b1;
        e = expect_res(idx, msk, en, pri, paddr);
        @(negedge clk);
        cmp_req = 1'b0; pri_match = 1'b0;
        chk(req, outs(), e);
    endtask

    function automatic bit pat(int i);
        return ^(12'(i) & 12'h5A3);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", outs(), IDLE_OUT);

        // R2: load every bit
        for (int i = 0; i < 4096; i++) wr(12'(i), pat(i));

        // R3 R7: full sweep, full mask, table enabled
        for (int i = 0; i < 4096; i++) cmp("R3", 12'(i), 12'hFFF, 1'b1, 1'b0, 12'h000);

        // R8: an idle cycle after a result returns to idle outputs
        cmp("R7", 12'h001, 12'hFFF, 1'b1, 1'b0, 12'h000);
        @(negedge clk);
        chk("R8", outs(), IDLE_OUT);

        // R4 R5 R6: masks x enable x primary
        for (int k = 0; k < 5; k++) begin
            logic [11:0] msk;
            msk = (k == 0) ? 12'h000 : (k == 1) ? 12'hF0F : (k == 2) ? 12'h0F0 :
                  (k == 3) ? 12'hAAA : 12'h7FE;
            for (int i = 0; i < 4096; i += 61) begin
                cmp("R4", 12'(i), msk, 1'b1, 1'b0, 12'h000);
                cmp("R5", 12'(i), msk, 1'b0, 1'b0, 12'h000);
                cmp("R6", 12'(i), msk, 1'b1, 1'b1, 12'(i * 5 + 3));
            end
        end

        // R2: write and compare to the same index in one cycle
        begin
            logic [18:0] e;
            bit nv;
            nv = ~model[12'h123];
            cfg_word  = mk_cfg(1'b1, 12'hFFF);
            comparand = {12'h123, 20'h0};
            cmp_req = 1'b1; wr_en = 1'b1; wr_idx = 12'h123; wr_val = nv;
            e = expect_res(12'h123, 12'hFFF, 1'b1, 1'b0, 12'h000);
            @(negedge clk);
            cmp_req = 1'b0; wr_en = 1'b0;
            chk("R2 same-cycle old value", outs(), e);
            model[12'h123] = nv;
            cmp("R2 new value", 12'h123, 12'hFFF, 1'b1, 1'b0, 12'h000);
        end

        // R9: sw_rst overrides a request
        cfg_word = mk_cfg(1'b1, 12'hFFF);
        comparand = {12'h010, 20'h0};
        cmp_req = 1'b1; pri_match = 1'b1; sw_rst = 1'b1;
        @(negedge clk);
        cmp_req = 1'b0; pri_match = 1'b0; sw_rst = 1'b0;
        chk("R9 sw_rst", outs(), IDLE_OUT);

        // R9: hardware reset keeps table contents
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 in reset", outs(), IDLE_OUT);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4096; i += 7) cmp("R9", 12'(i), 12'hFFF, 1'b1, 1'b0, 12'h000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule